// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a synchronous serial port for SPI-style links that can act either as the bus master or as a bus slave. A short register set sets it up. It selects the resting level of the serial clock and the clock edge on which data is captured. It sets the bit rate through a prescale divisor and a clock-rate factor. It also holds a loopback switch, a port enable, the master/slave choice, and a switch that keeps the slave from driving its data output.

In master mode the port generates the serial clock, the select line and the outgoing data, and samples the incoming data line. A word handed over on `tx_data` with a one-cycle `tx_start` becomes one 8-bit frame, shifted most significant bit first. At the end of the frame the received word appears on `rx_data` with a one-cycle `rx_done`. In slave mode the port samples the clock, select and data pins through synchronizers, returns the word presented on `tx_data` at the start of the frame, and reports each received word the same way. Each bus line has a separate output and output-enable pin, so the surrounding pad logic can turn the port around.

Top module: `spi_port`

## Requirements
- R1: After reset, address 0 and address 1 read 0, address 2 reads 2, `ssel_o` is 1, every output enable is 0 and `rx_done` is 0.
- R2: In master mode the serial clock output sits at the polarity bit (address 0, bit 6) whenever no frame is in progress, and it returns to that level after each frame.
- R3: With the phase bit (address 0, bit 7) at 0, the master samples its data input on the first edge of each bit, the one leaving the rest level, and changes `mosi_o` on the other edge. With the phase bit at 1, it changes `mosi_o` on the first edge and samples on the second. Words go out and come in most significant bit first.
- R4: Address 0 bits 15:8 hold the rate factor S. The serial clock period is P*(S+1) system clocks, where P is the prescale divisor.
- R5: Address 2 bits 7:0 hold P. A write stores the value with bit 0 cleared, and stores 2 when that result is 0, so P always reads back even and between 2 and 254.
- R6: Address 1 holds loopback at bit 0, enable at bit 1, slave select at bit 2 (0 = master, 1 = slave) and slave output off at bit 3. All other bits read 0.
- R7: With loopback set, the receiver takes the port's own serial output in place of the input pin, and the pin value has no effect on `rx_data`.
- R8: A write to the slave-select bit takes effect only if the enable bit was 0 before that write. While the port is enabled, the bit keeps its value.
- R9: In master mode `sclk_oe`, `mosi_oe` and `ssel_oe` follow the enable bit and `miso_oe` is 0. In slave mode `miso_oe` is 1 only while enabled with slave output off cleared, and the slave still receives when `miso_oe` is held low.
- R10: With the enable bit at 0, `tx_start` starts no frame, `ssel_o` stays 1, no output enable is set, and serial activity on the pins produces no `rx_done`.
- R11: In a master frame `ssel_o` is low for all 16 clock edges and rises half a bit period after the last edge. `rx_done` pulses for exactly one cycle, in the same cycle that `rx_data` takes the new word.
- R12: In slave mode the port receives `mosi_i` on the capture edge chosen by the phase bit. It drives `miso_o` with the `tx_data` value held when `ssel_i` fell, most significant bit first, and raises a single `rx_done` after the eighth capture. The slave clock must be no faster than one twelfth of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| tx_data | input | 8 | Word to send |
| tx_start | input | 1 | Master: start a frame with `tx_data` |
| rx_data | output | 8 | Last received word |
| rx_done | output | 1 | One-cycle pulse when `rx_data` is updated |
| busy | output | 1 | Frame in progress |
| sclk_o | output | 1 | Serial clock output (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock input (slave) |
| mosi_o | output | 1 | Master data output |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data input (slave) |
| ssel_o | output | 1 | Active-low select output (master) |
| ssel_oe | output | 1 | Select output enable |
| ssel_i | input | 1 | Active-low select input (slave) |
| miso_o | output | 1 | Slave data output |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data input (master) |

## Verification
The assertions assume that the rate fields, the polarity and the phase stay fixed while a frame is in progress, and that the tick spacing check depends on that. They also assume the slave clock runs at no more than one twelfth of the system clock, so every pin edge is seen once after the synchronizers. The stimulus changes the configuration only with the enable bit cleared and issues `tx_start` only while the port is idle. As bus master for the slave tests, the bench holds each clock level for 8 system clocks, giving 16 system clocks per bit, and it lowers the select line half a bit before the first clock edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int REG_W = 16;
  localparam int PRE_W = 8;
  localparam int SCR_W = 8;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             lbm;
    logic             sse;
    logic             ms;
    logic             sod;
    logic [SCR_W-1:0] scr;
    logic [PRE_W-1:0] pre;
  } port_cfg_t;

  // Force a prescale write onto the legal even range 2..254.
  function automatic logic [PRE_W-1:0] legal_prescale(input logic [PRE_W-1:0] v);
    logic [PRE_W-1:0] e;
    e = v & ~PRE_W'(1);
    return (e == '0) ? PRE_W'(2) : e;
  endfunction

  // System clocks per half bit: (prescale/2) * (rate factor + 1).
  function automatic int unsigned half_bit_clocks(input logic [PRE_W-2:0] half_pre,
                                                  input logic [SCR_W-1:0] scr);
    return 32'(half_pre) * (32'(scr) + 32'd1);
  endfunction

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output port_cfg_t        cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      cfg.pre <= PRE_W'(2);
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          cfg.cpol <= wdata[6];
          cfg.cpha <= wdata[7];
          cfg.scr  <= wdata[15:8];
        end
        2'd1: begin
          cfg.lbm <= wdata[0];
          cfg.sse <= wdata[1];
          if (!cfg.sse) cfg.ms <= wdata[2];
          cfg.sod <= wdata[3];
        end
        2'd2: cfg.pre <= legal_prescale(wdata[PRE_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {cfg.scr, cfg.cpha, cfg.cpol, 6'b0};
      2'd1:    rdata = {12'b0, cfg.sod, cfg.ms, cfg.sse, cfg.lbm};
      2'd2:    rdata = {{(REG_W-PRE_W){1'b0}}, cfg.pre};
      default: rdata = '0;
    endcase
  end

  AST_MS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.sse) |-> $stable(cfg.ms)); // R8

  AST_PRESCALE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pre[0] == 1'b0) && (cfg.pre != '0)); // R5

endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-2:0] half_pre,
  input  logic [SCR_W-1:0] scr,
  output logic             tick
);

  logic [PRE_W-2:0] pre_cnt;
  logic [SCR_W-1:0] rate_cnt;
  logic             pre_last;
  logic             rate_last;

  assign pre_last  = (pre_cnt == half_pre - (PRE_W-1)'(1));
  assign rate_last = (rate_cnt == scr);
  assign tick      = en & pre_last & rate_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (!en) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt  <= '0;
      rate_cnt <= rate_last ? '0 : rate_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // Independent cycle count between ticks for the rate check.
  logic [PRE_W+SCR_W:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '0;
    else if (!en || tick) gap <= '0;
    else                 gap <= gap + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (32'(gap) + 32'd1 == half_bit_clocks(half_pre, scr))); // R4

endmodule

// File: rtl/spi_port_master.sv
module spi_port_master #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              din,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              ssel_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);

  localparam int EDGES = 2 * WORD_W;
  localparam int CNT_W = $clog2(EDGES + 1);

  logic [CNT_W-1:0]  ecnt;
  logic              sclk_r;
  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-1:0] rx_sr;

  logic accept, edge_evt, leading, sample_evt, shift_evt, finish;

  assign accept     = run & start & ~busy;
  assign edge_evt   = busy & tick & (ecnt != CNT_W'(EDGES));
  assign leading    = ~ecnt[0];
  assign sample_evt = edge_evt & (leading ^ cpha);
  assign shift_evt  = edge_evt & (cpha ? (leading & (ecnt != '0))
                                       : (~leading & (ecnt != CNT_W'(EDGES - 1))));
  assign finish     = busy & tick & (ecnt == CNT_W'(EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ssel_n  <= 1'b1;
      sclk_r  <= 1'b0;
      ecnt    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        busy   <= 1'b0;
        ssel_n <= 1'b1;
        ecnt   <= '0;
      end else if (accept) begin
        busy   <= 1'b1;
        ssel_n <= 1'b0;
        ecnt   <= '0;
        tx_sr  <= tx_word;
        sclk_r <= cpol;
      end else begin
        if (edge_evt) begin
          sclk_r <= ~sclk_r;
          ecnt   <= ecnt + 1'b1;
        end
        if (sample_evt) rx_sr <= {rx_sr[WORD_W-2:0], din};
        if (shift_evt)  tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        if (finish) begin
          busy    <= 1'b0;
          ssel_n  <= 1'b1;
          rx_word <= rx_sr;
          done    <= 1'b1;
        end
      end
    end
  end

  assign sclk = busy ? sclk_r : cpol;
  assign mosi = tx_sr[WORD_W-1];

  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> $past(run && start)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sclk)); // R4

  AST_SSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sclk)) |-> !ssel_n); // R11

endmodule

// File: rtl/spi_port_slave.sv
module spi_port_slave #(
  parameter int WORD_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lbm,
  input  logic              sclk_pin,
  input  logic              mosi_pin,
  input  logic              ssel_pin,
  input  logic [WORD_W-1:0] tx_word,
  output logic              miso,
  output logic              in_frame,
  output logic [WORD_W-1:0] rx_word,
  output logic              done
);

  localparam int BIT_W = $clog2(WORD_W);

  logic [SYNC_N-1:0] sclk_sync, mosi_sync, ssel_sync;
  logic              sclk_d, ssel_d, first;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] tx_sr, rx_sr;

  logic sclk_s, mosi_s, ssel_s;
  logic frame_begin, toggled, lead_evt, trail_evt, sample_evt, shift_evt, din;

  assign sclk_s      = sclk_sync[SYNC_N-1];
  assign mosi_s      = mosi_sync[SYNC_N-1];
  assign ssel_s      = ssel_sync[SYNC_N-1];
  assign in_frame    = run & ~ssel_s;
  assign frame_begin = in_frame & ssel_d;
  assign toggled     = in_frame & ~frame_begin & (sclk_s != sclk_d);
  assign lead_evt    = toggled & (sclk_s != cpol);
  assign trail_evt   = toggled & (sclk_s == cpol);
  assign sample_evt  = cpha ? trail_evt : lead_evt;
  assign shift_evt   = cpha ? (lead_evt & ~first) : trail_evt;
  assign din         = lbm ? tx_sr[WORD_W-1] : mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      mosi_sync <= '0;
      ssel_sync <= '1;
      sclk_d    <= 1'b0;
      ssel_d    <= 1'b1;
      first     <= 1'b1;
      bit_cnt   <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      rx_word   <= '0;
      done      <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_N-2:0], sclk_pin};
      mosi_sync <= {mosi_sync[SYNC_N-2:0], mosi_pin};
      ssel_sync <= {ssel_sync[SYNC_N-2:0], ssel_pin};
      sclk_d    <= sclk_s;
      ssel_d    <= run ? ssel_s : 1'b1;
      done      <= 1'b0;
      if (frame_begin) begin
        tx_sr   <= tx_word;
        bit_cnt <= '0;
        first   <= 1'b1;
      end else begin
        if (sample_evt) begin
          rx_sr <= {rx_sr[WORD_W-2:0], din};
          if (bit_cnt == BIT_W'(WORD_W - 1)) begin
            rx_word <= {rx_sr[WORD_W-2:0], din};
            done    <= 1'b1;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (shift_evt) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        if (lead_evt)  first <= 1'b0;
      end
    end
  end

  assign miso = tx_sr[WORD_W-1];

  AST_SLAVE_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run)); // R10

  AST_SLAVE_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_start,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_done,
  output logic              busy,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              sclk_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              ssel_o,
  output logic              ssel_oe,
  input  logic              ssel_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i
);

  port_cfg_t cfg;

  logic m_run, s_run, tick;
  logic m_busy, m_done, m_din;
  logic s_busy, s_done;
  logic [WORD_W-1:0] m_rx, s_rx;

  assign m_run = cfg.sse & ~cfg.ms;
  assign s_run = cfg.sse &  cfg.ms;
  assign m_din = cfg.lbm ? mosi_o : miso_i;

  spi_port_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  spi_port_baud u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (m_busy),
    .half_pre (cfg.pre[PRE_W-1:1]),
    .scr      (cfg.scr),
    .tick     (tick)
  );

  spi_port_master #(.WORD_W(WORD_W)) u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (m_run),
    .cpol    (cfg.cpol),
    .cpha    (cfg.cpha),
    .tick    (tick),
    .start   (tx_start),
    .tx_word (tx_data),
    .din     (m_din),
    .busy    (m_busy),
    .sclk    (sclk_o),
    .mosi    (mosi_o),
    .ssel_n  (ssel_o),
    .rx_word (m_rx),
    .done    (m_done)
  );

  spi_port_slave #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (s_run),
    .cpol     (cfg.cpol),
    .cpha     (cfg.cpha),
    .lbm      (cfg.lbm),
    .sclk_pin (sclk_i),
    .mosi_pin (mosi_i),
    .ssel_pin (ssel_i),
    .tx_word  (tx_data),
    .miso     (miso_o),
    .in_frame (s_busy),
    .rx_word  (s_rx),
    .done     (s_done)
  );

  assign sclk_oe = m_run;
  assign mosi_oe = m_run;
  assign ssel_oe = m_run;
  assign miso_oe = s_run & ~cfg.sod;
  assign busy    = m_busy | s_busy;
  assign rx_done = m_done | s_done;
  assign rx_data = cfg.ms ? s_rx : m_rx;

  AST_ONE_ROLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_done && s_done)); // R9

endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  tx_data = '0;
  logic        tx_start = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_done, busy;
  logic        sclk_o, sclk_oe, mosi_o, mosi_oe, ssel_o, ssel_oe, miso_o, miso_oe;
  logic        sclk_i = 1'b0;
  logic        mosi_i = 1'b0;
  logic        ssel_i = 1'b1;
  logic        miso_i = 1'b0;

  always #4 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
    .tx_start(tx_start), .rx_data(rx_data), .rx_done(rx_done), .busy(busy),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .ssel_o(ssel_o), .ssel_oe(ssel_oe), .ssel_i(ssel_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Master transfer: the bench acts as the far-end slave.
  logic [7:0] m_cap, m_rx;
  int m_edges, m_t1, m_t3, m_tlast, m_trise, m_dcnt;

  task automatic master_xfer(input bit cpol, input bit cpha, input logic [7:0] tx,
                             input logic [7:0] mw);
    logic [7:0] msh;
    bit prev, lead;
    m_cap = '0; m_rx = '0; m_edges = 0; m_dcnt = 0;
    m_t1 = 0; m_t3 = 0; m_tlast = 0; m_trise = 0;
    msh = mw;
    @(negedge clk);
    tx_data = tx; tx_start = 1'b1; miso_i = msh[7];
    @(negedge clk);
    tx_start = 1'b0;
    prev = cpol;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (sclk_o != prev) begin
        m_edges++;
        lead = (sclk_o != cpol);
        if (m_edges == 1) m_t1 = cyc;
        if (m_edges == 3) m_t3 = cyc;
        m_tlast = cyc;
        if (lead ^ cpha) m_cap = {m_cap[6:0], mosi_o};
        if (cpha ? (lead && m_edges > 1) : !lead) begin
          msh = msh << 1;
          miso_i = msh[7];
        end
        prev = sclk_o;
      end
      if (rx_done) begin
        m_dcnt++;
        m_rx = rx_data;
      end
      if (ssel_o) begin
        m_trise = cyc;
        break;
      end
    end
    @(negedge clk);
    if (rx_done) m_dcnt++;
  endtask

  // Slave transfer: the bench acts as the master, 8 clocks per level.
  localparam int SH = 8;
  int  s_dcnt;
  bit  s_oe_hi;
  logic [7:0] s_cap;

  task automatic hold_level(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (rx_done) s_dcnt++;
      if (miso_oe) s_oe_hi = 1'b1;
    end
  endtask

  task automatic slave_xfer(input bit cpol, input bit cpha, input logic [7:0] mw);
    logic [7:0] sh;
    s_dcnt = 0; s_oe_hi = 1'b0; s_cap = '0;
    sh = mw;
    @(negedge clk);
    sclk_i = cpol; ssel_i = 1'b1;
    hold_level(SH);
    ssel_i = 1'b0; mosi_i = sh[7];
    hold_level(SH);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) s_cap = {s_cap[6:0], miso_o};
      else if (i > 0) begin sh = sh << 1; mosi_i = sh[7]; end
      sclk_i = ~cpol;
      hold_level(SH);
      if (cpha) s_cap = {s_cap[6:0], miso_o};
      else if (i < 7) begin sh = sh << 1; mosi_i = sh[7]; end
      sclk_i = cpol;
      hold_level(SH);
    end
    ssel_i = 1'b1;
    hold_level(2 * SH);
  endtask

  // cpol, cpha, lbm, scr, pre, tx word, far-end word
  localparam int NV = 6;
  localparam logic [34:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'd0, 8'd2, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b0, 8'd1, 8'd4, 8'h5A, 8'hC3},
    {1'b0, 1'b1, 1'b0, 8'd0, 8'd6, 8'h81, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'd2, 8'd2, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 1'b1, 8'd1, 8'd2, 8'h96, 8'hFF},
    {1'b1, 1'b1, 1'b1, 8'd0, 8'd4, 8'h3C, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all): actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, d); chk(d == 16'h0000, "R1 ctrl0 reset", d, 0);
    rd(2'd1, d); chk(d == 16'h0000, "R1 ctrl1 reset", d, 0);
    rd(2'd2, d); chk(d == 16'h0002, "R1 prescale reset", d, 2);
    chk(ssel_o == 1'b1 && rx_done == 1'b0, "R1 ssel/done reset", {ssel_o, rx_done}, 2);
    chk({sclk_oe, mosi_oe, ssel_oe, miso_oe} == 4'b0, "R1 enables reset",
        {sclk_oe, mosi_oe, ssel_oe, miso_oe}, 0);

    // R10: disabled master ignores tx_start
    @(negedge clk); tx_data = 8'h55; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (20) @(negedge clk);
    chk(ssel_o == 1'b1 && busy == 1'b0 && sclk_oe == 1'b0, "R10 master start ignored",
        {ssel_o, busy, sclk_oe}, 4);

    // Vector walk: master frames
    for (int v = 0; v < NV; v++) begin
      bit cpol, cpha, lbm;
      logic [7:0] scr, pre, tx, mw, expect_rx;
      {cpol, cpha, lbm, scr, pre, tx, mw} = VECS[v];
      wr(2'd1, 16'h0000);
      wr(2'd0, {scr, cpha, cpol, 6'b0});
      wr(2'd2, {8'h00, pre});
      wr(2'd1, {14'b0, 1'b1, lbm});
      rd(2'd0, d);
      chk(d == {scr, cpha, cpol, 6'b0}, "R4 ctrl0 readback", d, {scr, cpha, cpol, 6'b0});
      chk(sclk_o == cpol, "R2 rest level before frame", sclk_o, cpol);
      master_xfer(cpol, cpha, tx, mw);
      expect_rx = lbm ? tx : mw;
      chk(m_cap == tx, "R3 word on mosi", m_cap, tx);
      chk(m_rx == expect_rx, lbm ? "R7 loopback receive" : "R3 word from miso", m_rx, expect_rx);
      chk(m_t3 - m_t1 == int'(pre) * (int'(scr) + 1), "R4 bit period",
          m_t3 - m_t1, int'(pre) * (int'(scr) + 1));
      chk(m_edges == 16, "R11 clock edges", m_edges, 16);
      chk(m_trise - m_tlast == (int'(pre) / 2) * (int'(scr) + 1), "R11 select release gap",
          m_trise - m_tlast, (int'(pre) / 2) * (int'(scr) + 1));
      chk(m_dcnt == 1, "R11 single done", m_dcnt, 1);
      chk(sclk_o == cpol, "R2 rest level after frame", sclk_o, cpol);
    end

    // R5: prescale legalisation
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000); rd(2'd2, d); chk(d == 16'd2, "R5 zero becomes 2", d, 2);
    wr(2'd2, 16'h0007); rd(2'd2, d); chk(d == 16'd6, "R5 odd rounds down", d, 6);
    wr(2'd2, 16'h00FF); rd(2'd2, d); chk(d == 16'd254, "R5 top value", d, 254);
    wr(2'd2, 16'h0001); rd(2'd2, d); chk(d == 16'd2, "R5 one becomes 2", d, 2);

    // R6: ctrl1 layout, reserved bits zero
    wr(2'd1, 16'hFFFF); rd(2'd1, d); chk(d == 16'h000F, "R6 ctrl1 layout", d, 16'h000F);

    // R8: slave-select locked while enabled
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd1, 16'h0006); rd(2'd1, d); chk(d[2] == 1'b0, "R8 ms locked", d[2], 0);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0004); rd(2'd1, d); chk(d[2] == 1'b1, "R8 ms written when idle", d[2], 1);

    // R9: slave-output-off has no effect in master mode
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h000A);
    @(negedge clk);
    chk({sclk_oe, mosi_oe, ssel_oe, miso_oe} == 4'b1110, "R9 master enables with sod",
        {sclk_oe, mosi_oe, ssel_oe, miso_oe}, 4'b1110);

    // R12: slave frames
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0006);
    tx_data = 8'hC6;
    slave_xfer(1'b0, 1'b0, 8'h2B);
    chk(rx_data == 8'h2B, "R12 slave receive mode0", rx_data, 8'h2B);
    chk(s_cap == 8'hC6, "R12 slave miso mode0", s_cap, 8'hC6);
    chk(s_dcnt == 1, "R12 slave single done", s_dcnt, 1);
    chk(s_oe_hi == 1'b1, "R9 slave drives miso", s_oe_hi, 1);

    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h00C0);
    wr(2'd1, 16'h0006);
    tx_data = 8'h5E;
    slave_xfer(1'b1, 1'b1, 8'hD1);
    chk(rx_data == 8'hD1, "R12 slave receive mode3", rx_data, 8'hD1);
    chk(s_cap == 8'h5E, "R12 slave miso mode3", s_cap, 8'h5E);

    // R7: slave loopback ignores mosi pin
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0007);
    tx_data = 8'h93;
    slave_xfer(1'b0, 1'b0, 8'h00);
    chk(rx_data == 8'h93, "R7 slave loopback", rx_data, 8'h93);

    // R9: slave output off still receives
    wr(2'd1, 16'h0004);
    wr(2'd1, 16'h000E);
    tx_data = 8'hAA;
    slave_xfer(1'b0, 1'b0, 8'h6D);
    chk(s_oe_hi == 1'b0, "R9 sod holds miso_oe low", s_oe_hi, 0);
    chk(rx_data == 8'h6D, "R9 sod slave receives", rx_data, 8'h6D);

    // R10: disabled slave ignores serial activity
    held = rx_data;
    wr(2'd1, 16'h0004);
    slave_xfer(1'b0, 1'b0, 8'h11);
    chk(s_dcnt == 0, "R10 no done when disabled", s_dcnt, 0);
    chk(rx_data == held, "R10 rx unchanged when disabled", rx_data, held);
    chk(s_oe_hi == 1'b0, "R10 no miso drive when disabled", s_oe_hi, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule